// File: doc/BRIEF.md
# Sub-word Destination Write-Mask Generator

This block decodes the write controls of a vector instruction into byte enables for a 128-bit destination register. It takes three inputs: a lane-mode code that gives the element width (8, 16, 32 or 64 bits), an 8-bit destination mask and a 2-bit override code. Each mask bit covers one fixed 16-bit slice of the register, whatever the element width. Elements wider than 16 bits therefore own several mask bits, and those bits are expected to agree.

The override code asks for a half-width result placed in the lower or upper half of the register. In the wide modes it also drops the mask bits of the other half. In byte mode it changes how mask bits map onto bytes. The block reports the effective result element width and one error flag. The flag covers the reserved override code, an override in byte mode, and disagreeing duplicate mask bits. The decode is purely combinational, so the enables, the width and the flag all belong to the instruction on the inputs in the same cycle. The register-file write itself happens elsewhere.

Top module: `wmask_gen`

## Requirements
- R1: Encodings. `lane_mode` 0/1/2/3 selects 8/16/32/64-bit elements, and `dst_ovr` 0/1/2/3 means none/lower/upper/reserved. `byte_en` bit b enables byte b of the register, and `enc_err` is 0 when none of the error conditions in R5, R7 or R8 applies. All outputs follow the inputs combinationally.
- R2: In 32-bit mode, element k (k=0..3) enables bytes 4k..4k+3 when mask bit 2k is set.
- R3: In 64-bit mode, element k (k=0..1) enables bytes 8k..8k+7 when mask bit 4k is set.
- R4: In 32-bit and 64-bit modes, the lower override keeps only mask bits 3:0, so bytes 15:8 stay off. The upper override keeps only mask bits 7:4, so bytes 7:0 stay off.
- R5: In 32-bit and 64-bit modes, if the mask bits owned by one element disagree after the R4 restriction, `enc_err` is 1. The element's lowest mask bit still decides its enables.
- R6: In 8-bit mode with override code 0 or 3, mask bit i enables bytes 2i and 2i+1.
- R7: In 8-bit mode with the lower override, mask bit i enables byte i. With the upper override, it enables byte i+8. Either case sets `enc_err`.
- R8: Override code 3 sets `enc_err` in every mode, and the enables are then formed as with no override.
- R9: `res_lg2w` is the log2 of the result element width in bits: 3 + `lane_mode`, minus 1 when the override code is 1 or 2.
- R10: In 16-bit mode, mask bit i enables bytes 2i and 2i+1, and no override restricts the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lane_mode | input | 2 | Element width code: 0=8, 1=16, 2=32, 3=64 bits |
| dst_mask | input | 8 | Destination mask, one bit per 16-bit slice |
| dst_ovr | input | 2 | Override code: 0 none, 1 lower, 2 upper, 3 reserved |
| byte_en | output | 16 | Byte enables for the 128-bit destination |
| res_lg2w | output | 3 | log2 of the effective result element width in bits |
| enc_err | output | 1 | Illegal or inconsistent encoding |

## Verification
All 256 mask values are tried in every mode and override pairing. This separates the four slice-to-byte mappings and shows that the override confines writes to one half in the wide modes but not in 16-bit mode. Directed masks follow, with a single bit set inside a 32-bit or 64-bit element: the leader bit alone, or a non-leader bit alone. These tell the leader-decides rule apart from an OR or AND of the element's bits, and show that the mismatch flag ignores bits that the override has discarded. Seeded random patterns then repeat the comparison in a shuffled order.

// File: rtl/wmask_pkg.sv
package wmask_pkg;

    typedef enum logic [1:0] {
        LM_B8  = 2'd0,
        LM_B16 = 2'd1,
        LM_B32 = 2'd2,
        LM_B64 = 2'd3
    } lane_mode_e;

    typedef enum logic [1:0] {
        OV_NONE  = 2'd0,
        OV_LOWER = 2'd1,
        OV_UPPER = 2'd2,
        OV_RSVD  = 2'd3
    } ovr_e;

    // Number of slice widths that lane grouping can take (1, 2, 4 slices)
    localparam int unsigned NUM_GROUPINGS = 3;

    function automatic logic is_wide(lane_mode_e m);
        return (m == LM_B32) || (m == LM_B64);
    endfunction

    function automatic logic is_halving(ovr_e o);
        return (o == OV_LOWER) || (o == OV_UPPER);
    endfunction

    // Index of the grouping (log2 of slices per lane) used by a mode
    function automatic logic [1:0] grouping_of(lane_mode_e m);
        case (m)
            LM_B32:  return 2'd1;
            LM_B64:  return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/wmask_restrict.sv
module wmask_restrict
    import wmask_pkg::*;
#(
    parameter int unsigned NUM_SLICES = 8
) (
    input  lane_mode_e            mode,
    input  ovr_e                  ovr,
    input  logic [NUM_SLICES-1:0] mask_in,
    output logic [NUM_SLICES-1:0] mask_out
);
    localparam int unsigned HALF = NUM_SLICES / 2;

    logic [NUM_SLICES-1:0] keep;

    always_comb begin
        keep = '1;
        if (is_wide(mode)) begin
            if (ovr == OV_LOWER)      keep = {{(NUM_SLICES-HALF){1'b0}}, {HALF{1'b1}}};
            else if (ovr == OV_UPPER) keep = {{(NUM_SLICES-HALF){1'b1}}, {HALF{1'b0}}};
        end
        mask_out = mask_in & keep;
    end
endmodule

// File: rtl/wmask_lane_expand.sv
module wmask_lane_expand #(
    parameter int unsigned NUM_SLICES  = 8,
    parameter int unsigned LANE_SLICES = 2
) (
    input  logic [NUM_SLICES-1:0] mask,
    output logic [NUM_SLICES-1:0] slice_en,
    output logic                  mismatch
);
    localparam int unsigned NUM_LANES = NUM_SLICES / LANE_SLICES;

    logic [NUM_LANES-1:0] lane_bad;

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        logic leader;
        logic [LANE_SLICES-1:0] bits;
        assign bits   = mask[k*LANE_SLICES +: LANE_SLICES];
        assign leader = bits[0];
        assign slice_en[k*LANE_SLICES +: LANE_SLICES] = {LANE_SLICES{leader}};
        assign lane_bad[k] = |(bits ^ {LANE_SLICES{leader}});
    end

    assign mismatch = |lane_bad;
endmodule

// File: rtl/wmask_byte_path.sv
module wmask_byte_path #(
    parameter int unsigned NUM_SLICES = 8
) (
    input  logic [NUM_SLICES-1:0]   mask,
    input  logic                    upper,
    output logic [2*NUM_SLICES-1:0] byte_en
);
    for (genvar i = 0; i < NUM_SLICES; i++) begin : g_byte
        assign byte_en[i]            = mask[i] & ~upper;
        assign byte_en[i+NUM_SLICES] = mask[i] & upper;
    end
endmodule

// File: rtl/wmask_gen.sv
module wmask_gen
    import wmask_pkg::*;
#(
    parameter int unsigned NUM_SLICES  = 8,
    parameter int unsigned SLICE_BYTES = 2
) (
    input  logic [1:0]                        lane_mode,
    input  logic [NUM_SLICES-1:0]             dst_mask,
    input  logic [1:0]                        dst_ovr,
    output logic [NUM_SLICES*SLICE_BYTES-1:0] byte_en,
    output logic [2:0]                        res_lg2w,
    output logic                              enc_err
);
    localparam int unsigned NUM_BYTES = NUM_SLICES * SLICE_BYTES;
    localparam int unsigned HALF_B    = NUM_BYTES / 2;

    lane_mode_e mode;
    ovr_e       ovr;
    assign mode = lane_mode_e'(lane_mode);
    assign ovr  = ovr_e'(dst_ovr);

    logic [NUM_SLICES-1:0] mask_r;

    wmask_restrict #(.NUM_SLICES(NUM_SLICES)) u_restrict (
        .mode     (mode),
        .ovr      (ovr),
        .mask_in  (dst_mask),
        .mask_out (mask_r)
    );

    logic [NUM_SLICES-1:0] slice_v [NUM_GROUPINGS];
    logic [NUM_GROUPINGS-1:0] mism_v;

    for (genvar g = 0; g < NUM_GROUPINGS; g++) begin : g_group
        wmask_lane_expand #(
            .NUM_SLICES  (NUM_SLICES),
            .LANE_SLICES (1 << g)
        ) u_expand (
            .mask     (mask_r),
            .slice_en (slice_v[g]),
            .mismatch (mism_v[g])
        );
    end

    logic [NUM_BYTES-1:0] bp_en;

    wmask_byte_path #(.NUM_SLICES(NUM_SLICES)) u_bytes (
        .mask    (dst_mask),
        .upper   (ovr == OV_UPPER),
        .byte_en (bp_en)
    );

    logic [1:0]            grp;
    logic [NUM_SLICES-1:0] slice_sel;
    logic [NUM_BYTES-1:0]  slice_bytes;
    logic                  byte_ovr;

    assign grp       = grouping_of(mode);
    assign slice_sel = slice_v[grp];
    assign byte_ovr  = (mode == LM_B8) && is_halving(ovr);

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_spread
        assign slice_bytes[b] = slice_sel[b / SLICE_BYTES];
    end

    assign byte_en  = byte_ovr ? bp_en : slice_bytes;
    assign res_lg2w = 3'(3 + {1'b0, lane_mode}) - {2'b00, is_halving(ovr)};
    assign enc_err  = (ovr == OV_RSVD)
                    || ((mode == LM_B8) && (ovr != OV_NONE))
                    || mism_v[grp];

    always_comb begin
        p_rsvd_err_r8: assert (!(dst_ovr == 2'd3) || enc_err)
            else $error("reserved override without error");
        p_lower_half_r4: assert (!(lane_mode[1] && dst_ovr == 2'd1) || byte_en[NUM_BYTES-1:HALF_B] == '0)
            else $error("lower override wrote upper half");
        p_upper_half_r4: assert (!(lane_mode[1] && dst_ovr == 2'd2) || byte_en[HALF_B-1:0] == '0)
            else $error("upper override wrote lower half");
        p_byte_ovr_err_r7: assert (!(lane_mode == 2'd0 && dst_ovr != 2'd0) || enc_err)
            else $error("byte-mode override without error");
        p_b16_noerr_r10: assert (!(lane_mode == 2'd1 && dst_ovr != 2'd3) || !enc_err)
            else $error("16-bit mode flagged");
        p_width_r9: assert (res_lg2w >= 3'd2 && res_lg2w <= 3'd6)
            else $error("width out of range");
    end
endmodule

// File: tb/wmask_gen_tb.sv
module wmask_gen_tb;
    logic       clk = 1'b0;
    logic [1:0] lane_mode;
    logic [7:0] dst_mask;
    logic [1:0] dst_ovr;
    logic [15:0] byte_en;
    logic [2:0]  res_lg2w;
    logic        enc_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    wmask_gen u_dut (
        .lane_mode (lane_mode),
        .dst_mask  (dst_mask),
        .dst_ovr   (dst_ovr),
        .byte_en   (byte_en),
        .res_lg2w  (res_lg2w),
        .enc_err   (enc_err)
    );

    // Reference: byte enables from requirements R2, R3, R4, R6, R7, R8, R10
    function automatic logic [15:0] ref_en(int m, int o, logic [7:0] k);
        logic [15:0] r = '0;
        logic [7:0]  mk = k;
        int span;
        if (m == 0 && (o == 1 || o == 2)) begin
            for (int b = 0; b < 16; b++)
                if ((o == 2) == (b >= 8)) r[b] = k[b % 8];
            return r;
        end
        if (m >= 2 && o == 1) mk = k & 8'h0F;
        if (m >= 2 && o == 2) mk = k & 8'hF0;
        span = (m == 3) ? 4 : (m == 2) ? 2 : 1;
        for (int b = 0; b < 16; b++) r[b] = mk[((b / 2) / span) * span];
        return r;
    endfunction

    function automatic logic ref_err(int m, int o, logic [7:0] k);
        logic [7:0] mk = k;
        int span;
        if (o == 3) return 1'b1;
        if (m == 0 && o != 0) return 1'b1;
        if (m < 2) return 1'b0;
        if (o == 1) mk = k & 8'h0F;
        if (o == 2) mk = k & 8'hF0;
        span = (m == 3) ? 4 : 2;
        for (int s = 0; s < 8; s++)
            if (mk[s] != mk[(s / span) * span]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [2:0] ref_w(int m, int o);
        return 3'(m + 3 - ((o == 1 || o == 2) ? 1 : 0));
    endfunction

    function automatic string en_tag(int m, int o);
        if (m == 0) return (o == 1 || o == 2) ? "R7" : "R6";
        if (m == 1) return "R10";
        if (o == 1 || o == 2) return "R4";
        return (m == 2) ? "R2" : "R3";
    endfunction

    function automatic string err_tag(int m, int o, logic exp);
        if (o == 3) return "R8";
        if (m == 0 && o != 0) return "R7";
        return exp ? "R5" : "R1";
    endfunction

    task automatic apply_and_check(int m, int o, logic [7:0] k);
        logic [15:0] e_en;
        logic        e_err;
        logic [2:0]  e_w;
        @(negedge clk);
        lane_mode = 2'(m);
        dst_ovr   = 2'(o);
        dst_mask  = k;
        #2;
        e_en  = ref_en(m, o, k);
        e_err = ref_err(m, o, k);
        e_w   = ref_w(m, o);
        checks += 3;
        if (byte_en !== e_en) begin
            errors++;
            $display("FAIL %s byte_en mode=%0d ovr=%0d mask=%h actual=%h expected=%h",
                     en_tag(m, o), m, o, k, byte_en, e_en);
        end
        if (enc_err !== e_err) begin
            errors++;
            $display("FAIL %s enc_err mode=%0d ovr=%0d mask=%h actual=%b expected=%b",
                     err_tag(m, o, e_err), m, o, k, enc_err, e_err);
        end
        if (res_lg2w !== e_w) begin
            errors++;
            $display("FAIL R9 res_lg2w mode=%0d ovr=%0d actual=%0d expected=%0d",
                     m, o, res_lg2w, e_w);
        end
    endtask

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        lane_mode = '0;
        dst_ovr   = '0;
        dst_mask  = '0;
        // Idle state (R1): all-zero inputs give no enables and no error
        apply_and_check(0, 0, 8'h00);
        // Directed leader-bit cases (R5, R2, R3, R4)
        apply_and_check(2, 0, 8'h01);  // R2 leader only: lane 0 on, flagged
        apply_and_check(2, 0, 8'h02);  // R5 non-leader only: lane 0 off, flagged
        apply_and_check(3, 0, 8'h08);  // R5 64-bit non-leader
        apply_and_check(3, 0, 8'h0F);  // R3 clean lane 0
        apply_and_check(2, 1, 8'h3C);  // R4 dropped half ignored for R5
        apply_and_check(3, 2, 8'h1F);  // R4 upper, lower junk dropped
        apply_and_check(1, 2, 8'hFF);  // R10 override does not restrict
        apply_and_check(0, 2, 8'h81);  // R7 upper byte mapping
        apply_and_check(0, 3, 8'h55);  // R8 reserved in byte mode
        // Exhaustive sweep
        for (int m = 0; m < 4; m++)
            for (int o = 0; o < 4; o++)
                for (int k = 0; k < 256; k++)
                    apply_and_check(m, o, 8'(k));
        // Seeded random
        seed_dummy = $urandom(32'h5eed);
        for (int n = 0; n < 2000; n++)
            apply_and_check(int'($urandom_range(3)), int'($urandom_range(3)), 8'($urandom));
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule